// File: doc/BRIEF.md
# External Bus Cycle Sequencer

This block turns bus cycle requests from an 8-bit processor core into timed external memory and I/O cycles. It runs from the crystal-rate clock and divides it by two to produce the system clock. Every T-state therefore spans two crystal periods. The first period is the high half of the system clock and the second is the low half. Strobes are placed on those half-state boundaries.

The core offers a request on a valid/ready handshake. A request is a cycle kind, an address that has already been translated, and write data. The sequencer then steps through T1, T2, optional wait states and T3, driving the address, the active-low strobes and the data bus. It pulses `rsp_valid` in the last crystal period of the cycle, together with any read data. The core has no way to hold off that response. The request side is where back-pressure lives: `req_ready` rises only while the sequencer is idle or finishing a cycle. This allows back-to-back cycles with no idle gap. Internal cycles take a single T-state and touch no strobe.

Top module: `bus_cycle_seq`

## Requirements
- R1: `sys_clk` toggles on every crystal clock edge after reset. It is high in the first crystal period of every T-state and low in the second.
- R2: A memory or I/O cycle without waits lasts six crystal periods (T1, T2, T3). `rsp_valid` is high only in the last of them.
- R3: An internal cycle lasts two crystal periods (T1 only). `rsp_valid` is high in the second period, and every strobe stays high with `data_oe` low.
- R4: `wait_n` is sampled at the falling edge of `sys_clk` inside T2 and inside each wait state. Each sample taken low inserts one more wait state of two crystal periods between T2 and T3.
- R5: During an opcode fetch, `m1_n` is low from the first half of T1 through the end of T3.
- R6: `addr_o` carries the accepted request address from the first half of T1 through the end of T3.
- R7: Reads assert `rd_n` low from the second half of T1 through the end of T3, with `mreq_n` low for memory kinds or `iorq_n` low for I/O kinds. Strobes of the other space stay high.
- R8: Writes drive `data_o` with `data_oe` high from T1 through T3. They assert `wr_n` low from the second half of T2 through the end of T3, with `mreq_n` or `iorq_n` low from the second half of T1.
- R9: For reads, `data_i` is captured at the falling edge of `sys_clk` within T3 and presented on `rsp_rdata` while `rsp_valid` is high.
- R10: `req_ready` is high in the second half of the system clock while idle, and in the last crystal period of a cycle. It is low at all other times. A request that is valid during that last period starts T1 on the very next crystal period.
- R11: `req_kind` encoding: 0 opcode fetch, 1 memory read, 2 memory write, 3 I/O read, 4 I/O write, 5 internal. Codes 6 and 7 run as internal cycles.
- R12: While reset is held, all strobes are high, `data_oe` is low, and `rsp_valid` and `req_ready` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_xtal | input | 1 | Crystal-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Core offers a cycle request |
| req_ready | output | 1 | Sequencer accepts the request on this edge |
| req_kind | input | 3 | Cycle kind code |
| req_addr | input | 20 | Translated address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Cycle completes (one crystal period) |
| rsp_rdata | output | 8 | Captured read data |
| sys_clk | output | 1 | System clock, crystal divided by two |
| addr_o | output | 20 | External address bus |
| data_o | output | 8 | External data bus, outgoing |
| data_oe | output | 1 | Data bus output enable |
| data_i | input | 8 | External data bus, incoming |
| m1_n | output | 1 | Opcode fetch marker, active low |
| mreq_n | output | 1 | Memory request, active low |
| iorq_n | output | 1 | I/O request, active low |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| wait_n | input | 1 | Wait request, active low |

## Verification
The bench targets the edges of each strobe window, in crystal periods.

- A read strobe raised in the first half of T1 would fail the check on that period.
- A write strobe raised in T2's first half would fail the same way.
- A wait input sampled at the wrong half, or one state too late, shifts `rsp_valid` and the end of the strobes by two periods, and the bench catches the shift.
- Back-to-back requests catch a design that inserts an idle T-state after a completed cycle.
- Kind codes 6 and 7, and the internal kind, catch strobes that leak into a one-state cycle.
- Reads with distinct data patterns catch capture taken from the wrong half of T3.

// File: rtl/bus_seq_pkg.sv
package bus_seq_pkg;

  typedef enum logic [2:0] {
    KIND_FETCH = 3'd0,
    KIND_MRD   = 3'd1,
    KIND_MWR   = 3'd2,
    KIND_IORD  = 3'd3,
    KIND_IOWR  = 3'd4,
    KIND_INTL  = 3'd5
  } kind_e;

  typedef enum logic [2:0] {
    TS_IDLE = 3'd0,
    TS_T1   = 3'd1,
    TS_T2   = 3'd2,
    TS_TW   = 3'd3,
    TS_T3   = 3'd4
  } tstate_e;

  typedef struct packed {
    logic is_fetch;
    logic is_mem;
    logic is_io;
    logic is_rd;
    logic is_wr;
    logic is_intl;
  } cyc_attr_t;

  function automatic cyc_attr_t decode_kind(input logic [2:0] code);
    cyc_attr_t a;
    a = '0;
    case (code)
      KIND_FETCH: begin a.is_fetch = 1'b1; a.is_mem = 1'b1; a.is_rd = 1'b1; end
      KIND_MRD:   begin a.is_mem = 1'b1; a.is_rd = 1'b1; end
      KIND_MWR:   begin a.is_mem = 1'b1; a.is_wr = 1'b1; end
      KIND_IORD:  begin a.is_io = 1'b1; a.is_rd = 1'b1; end
      KIND_IOWR:  begin a.is_io = 1'b1; a.is_wr = 1'b1; end
      default:    a.is_intl = 1'b1;
    endcase
    return a;
  endfunction

endpackage

// File: rtl/bus_phase_gen.sv
module bus_phase_gen (
  input  logic clk,
  input  logic rst_n,
  output logic ph,
  output logic sys_clk
);
  // ph = 0: first (high) half of a T-state, ph = 1: second (low) half
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph <= 1'b0;
    else        ph <= ~ph;
  end

  assign sys_clk = rst_n & ~ph;
endmodule

// File: rtl/bus_tstate_fsm.sv
module bus_tstate_fsm
  import bus_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    ph,
  input  logic    req_valid,
  input  logic    cur_intl,
  input  logic    wait_n,
  output tstate_e st,
  output logic    done,
  output logic    ready,
  output logic    accept,
  output logic    cap_rdata
);
  tstate_e st_nx;
  logic    go_q;   // wait_n sampled at the sys_clk falling edge of T2/TW

  assign done      = ph && ((st == TS_T3) || (st == TS_T1 && cur_intl));
  assign ready     = rst_n && ((st == TS_IDLE && ph) || done);
  assign accept    = ready && req_valid;
  assign cap_rdata = (st == TS_T3) && !ph;

  always_comb begin
    st_nx = st;
    if (ph) begin
      unique case (st)
        TS_IDLE: st_nx = accept ? TS_T1 : TS_IDLE;
        TS_T1:   st_nx = cur_intl ? (accept ? TS_T1 : TS_IDLE) : TS_T2;
        TS_T2,
        TS_TW:   st_nx = go_q ? TS_T3 : TS_TW;
        TS_T3:   st_nx = accept ? TS_T1 : TS_IDLE;
        default: st_nx = TS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= TS_IDLE;
      go_q <= 1'b1;
    end else begin
      st <= st_nx;
      if (!ph && (st == TS_T2 || st == TS_TW)) go_q <= wait_n;
    end
  end
endmodule

// File: rtl/bus_strobe_dec.sv
module bus_strobe_dec
  import bus_seq_pkg::*;
(
  input  tstate_e   st,
  input  logic      ph,
  input  cyc_attr_t attr,
  output logic      m1_n,
  output logic      mreq_n,
  output logic      iorq_n,
  output logic      rd_n,
  output logic      wr_n,
  output logic      data_oe
);
  logic bus_cyc, late, wr_win;

  assign bus_cyc = (st != TS_IDLE) && !attr.is_intl;
  assign late    = bus_cyc && !(st == TS_T1 && !ph);
  assign wr_win  = bus_cyc && attr.is_wr &&
                   ((st == TS_T2 && ph) || st == TS_TW || st == TS_T3);

  assign m1_n    = !(bus_cyc && attr.is_fetch);
  assign mreq_n  = !(late && attr.is_mem);
  assign iorq_n  = !(late && attr.is_io);
  assign rd_n    = !(late && attr.is_rd);
  assign wr_n    = !wr_win;
  assign data_oe = bus_cyc && attr.is_wr;
endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
  import bus_seq_pkg::*;
#(
  parameter int AW = 20,
  parameter int DW = 8
) (
  input  logic          clk_xtal,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [2:0]    req_kind,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic          sys_clk,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] data_o,
  output logic          data_oe,
  input  logic [DW-1:0] data_i,
  output logic          m1_n,
  output logic          mreq_n,
  output logic          iorq_n,
  output logic          rd_n,
  output logic          wr_n,
  input  logic          wait_n
);
  logic          ph, done, accept, cap_rdata;
  tstate_e       st;
  cyc_attr_t     attr_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q, rdata_q;

  bus_phase_gen u_phase (
    .clk(clk_xtal), .rst_n(rst_n), .ph(ph), .sys_clk(sys_clk)
  );

  bus_tstate_fsm u_fsm (
    .clk(clk_xtal), .rst_n(rst_n), .ph(ph), .req_valid(req_valid),
    .cur_intl(attr_q.is_intl), .wait_n(wait_n), .st(st), .done(done),
    .ready(req_ready), .accept(accept), .cap_rdata(cap_rdata)
  );

  bus_strobe_dec u_dec (
    .st(st), .ph(ph), .attr(attr_q), .m1_n(m1_n), .mreq_n(mreq_n),
    .iorq_n(iorq_n), .rd_n(rd_n), .wr_n(wr_n), .data_oe(data_oe)
  );

  always_ff @(posedge clk_xtal or negedge rst_n) begin
    if (!rst_n) begin
      attr_q  <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      if (accept) begin
        attr_q  <= decode_kind(req_kind);
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end
      if (cap_rdata) rdata_q <= data_i;
    end
  end

  assign rsp_valid = done;
  assign rsp_rdata = rdata_q;
  assign addr_o    = addr_q;
  assign data_o    = wdata_q;
endmodule

// File: rtl/bus_seq_chk.sv
module bus_seq_chk #(
  parameter int AW = 20
) (
  input logic          clk_xtal,
  input logic          rst_n,
  input logic          sys_clk,
  input logic [AW-1:0] addr_o,
  input logic          data_oe,
  input logic          m1_n,
  input logic          mreq_n,
  input logic          iorq_n,
  input logic          rd_n,
  input logic          wr_n,
  input logic          req_ready,
  input logic          rsp_valid
);
  p_sysclk_toggles_r1: assert property (@(posedge clk_xtal) disable iff (!rst_n)
    $past(rst_n) |-> sys_clk != $past(sys_clk));

  p_space_excl_r7: assert property (@(posedge clk_xtal) disable iff (!rst_n)
    !(!mreq_n && !iorq_n));

  p_rd_wr_excl_r8: assert property (@(posedge clk_xtal) disable iff (!rst_n)
    !(!rd_n && !wr_n));

  p_wr_drives_bus_r8: assert property (@(posedge clk_xtal) disable iff (!rst_n)
    !wr_n |-> data_oe);

  p_fetch_is_mem_r5: assert property (@(posedge clk_xtal) disable iff (!rst_n)
    !m1_n |-> iorq_n);

  p_addr_held_r6: assert property (@(posedge clk_xtal) disable iff (!rst_n)
    (!mreq_n && $past(!mreq_n)) |-> $stable(addr_o));

  p_done_ready_r10: assert property (@(posedge clk_xtal) disable iff (!rst_n)
    rsp_valid |-> req_ready);

  p_done_once_r2: assert property (@(posedge clk_xtal) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
endmodule

bind bus_cycle_seq bus_seq_chk #(.AW(AW)) u_chk (
  .clk_xtal(clk_xtal), .rst_n(rst_n), .sys_clk(sys_clk), .addr_o(addr_o),
  .data_oe(data_oe), .m1_n(m1_n), .mreq_n(mreq_n), .iorq_n(iorq_n),
  .rd_n(rd_n), .wr_n(wr_n), .req_ready(req_ready), .rsp_valid(rsp_valid)
);

// File: tb/sim_bus_cycle_seq.sv
`timescale 1ns/1ps
module sim_bus_cycle_seq;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req_valid = 1'b0, req_ready;
  logic [2:0]  req_kind = '0;
  logic [19:0] req_addr = '0;
  logic [7:0]  req_wdata = '0, rsp_rdata, data_o, data_i = '0;
  logic        rsp_valid, sys_clk, data_oe, m1_n, mreq_n, iorq_n, rd_n, wr_n;
  logic        wait_n = 1'b1;
  logic [19:0] addr_o;
  int          nchk = 0, nfail = 0;
  bit          finished = 0;

  always #10 clk = ~clk;  // 50 MHz crystal-rate clock

  bus_cycle_seq u0 (
    .clk_xtal(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .sys_clk(sys_clk),
    .addr_o(addr_o), .data_o(data_o), .data_oe(data_oe), .data_i(data_i),
    .m1_n(m1_n), .mreq_n(mreq_n), .iorq_n(iorq_n), .rd_n(rd_n), .wr_n(wr_n),
    .wait_n(wait_n)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s at %0t: actual=%0h expected=%0h", tag, $time, act, exp);
    end
  endtask

  // Runs one cycle and checks every crystal period of it.
  task automatic run_cyc(input logic [2:0] kind, input logic [19:0] a, input logic [7:0] wd,
                         input logic [7:0] rdv, input int nw, input bit pre,
                         input bit nv, input logic [2:0] nk, input logic [19:0] na,
                         input logic [7:0] nwd);
    bit    isf  = (kind == 3'd0);
    bit    ism  = (kind <= 3'd2);
    bit    isio = (kind == 3'd3 || kind == 3'd4);
    bit    isr  = (kind == 3'd0 || kind == 3'd1 || kind == 3'd3);
    bit    isw  = (kind == 3'd2 || kind == 3'd4);
    bit    intl = (kind > 3'd4);
    int    len  = intl ? 2 : 6 + 2 * nw;
    string stag = intl ? ((kind > 3'd5) ? "R11" : "R3") : "R7";
    string dtag = intl ? ((kind > 3'd5) ? "R11" : "R3") : ((nw > 0) ? "R4" : "R2");
    data_i = rdv;
    if (!pre) begin
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1; req_kind = kind; req_addr = a; req_wdata = wd;
    end
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      if (k == 0) req_valid = 1'b0;
      chk("R1 sys_clk", sys_clk, (k % 2 == 0));
      chk({dtag, " rsp_valid"}, rsp_valid, (k == len - 1));
      chk("R10 req_ready", req_ready, (k == len - 1));
      chk({intl ? stag : "R5", " m1_n"}, m1_n, !(isf && !intl));
      chk({stag, " mreq_n"}, mreq_n, !(ism && k >= 1));
      chk({stag, " iorq_n"}, iorq_n, !(isio && k >= 1));
      chk({stag, " rd_n"}, rd_n, !(isr && k >= 1));
      chk({intl ? stag : "R8", " wr_n"}, wr_n, !(isw && k >= 3));
      chk({intl ? stag : "R8", " data_oe"}, data_oe, isw);
      if (isw) chk("R8 data_o", data_o, wd);
      if (!intl) chk("R6 addr_o", addr_o, a);
      if (isr && k == len - 1) chk("R9 rsp_rdata", rsp_rdata, rdv);
      // wait_n is sampled at the end of T2/TW first halves: k = 2, 4, 6...
      wait_n = !(k % 2 == 0 && k >= 2 && (k - 2) / 2 < nw);
      if (k == len - 1 && nv) begin
        req_valid = 1'b1; req_kind = nk; req_addr = na; req_wdata = nwd;
      end
    end
    wait_n = 1'b1;
  endtask

  task automatic t_reset();
    #5;
    chk("R12 m1_n", m1_n, 1); chk("R12 mreq_n", mreq_n, 1);
    chk("R12 iorq_n", iorq_n, 1); chk("R12 rd_n", rd_n, 1);
    chk("R12 wr_n", wr_n, 1); chk("R12 data_oe", data_oe, 0);
    chk("R12 rsp_valid", rsp_valid, 0); chk("R12 req_ready", req_ready, 0);
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_idle();
    logic s0, r0;
    @(negedge clk);
    s0 = sys_clk; r0 = req_ready;
    @(negedge clk);
    chk("R1 sys_clk toggles", sys_clk, !s0);
    chk("R10 idle ready alternates", req_ready, !r0);
    chk("R10 idle ready in low half", req_ready, !sys_clk);
    chk("R12 idle strobes", {m1_n, mreq_n, iorq_n, rd_n, wr_n}, 5'h1f);
  endtask

  task automatic t_fetch();
    run_cyc(3'd0, 20'hABCDE, 8'h00, 8'h3C, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_mem_read_wait();
    run_cyc(3'd1, 20'h12345, 8'h00, 8'hC5, 2, 0, 0, 0, 0, 0);
    run_cyc(3'd0, 20'hFFFFF, 8'h00, 8'hA1, 1, 0, 0, 0, 0, 0);
  endtask

  task automatic t_mem_write();
    run_cyc(3'd2, 20'h00010, 8'h96, 8'h00, 0, 0, 0, 0, 0, 0);
    run_cyc(3'd2, 20'h80001, 8'h5A, 8'h00, 1, 0, 0, 0, 0, 0);
  endtask

  task automatic t_io();
    run_cyc(3'd3, 20'h000FE, 8'h00, 8'h77, 1, 0, 0, 0, 0, 0);
    run_cyc(3'd4, 20'h00042, 8'hE1, 8'h00, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_internal();
    run_cyc(3'd5, 20'h11111, 8'hFF, 8'h00, 0, 0, 0, 0, 0, 0);
    run_cyc(3'd7, 20'h22222, 8'hFF, 8'h00, 0, 0, 0, 0, 0, 0);
    run_cyc(3'd6, 20'h33333, 8'hFF, 8'h00, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_back_to_back();
    run_cyc(3'd0, 20'h00100, 8'h00, 8'h11, 0, 0, 1, 3'd2, 20'h00200, 8'h22);
    run_cyc(3'd2, 20'h00200, 8'h22, 8'h00, 0, 1, 1, 3'd5, 20'h00300, 8'h00);
    run_cyc(3'd5, 20'h00300, 8'h00, 8'h00, 0, 1, 1, 3'd3, 20'h00400, 8'h00);
    run_cyc(3'd3, 20'h00400, 8'h00, 8'h44, 1, 1, 0, 0, 0, 0);
  endtask

  initial begin
    t_reset();
    t_idle();
    t_fetch();
    t_mem_read_wait();
    t_mem_write();
    t_io();
    t_internal();
    t_back_to_back();
    t_idle();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nchk++; nfail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end
endmodule